// File: doc/BRIEF.md
# Raster Line Timing Generator

This block keeps the beam position of a character/bitmap video controller. A cycle counter walks across each raster line and a line counter walks down the frame. Three frame standards can be selected: a 262-line frame of 64-cycle lines, a 263-line frame of 65-cycle lines, and a 312-line frame of 63-cycle lines. From the line position the block decodes the top border, the display area, the bottom border and vertical blank. It also flags the window of lines in which bad lines may occur. Downstream fetch and pixel logic use these flags.

The standard select may change at any time. The block loads the new value only when the line counter wraps to 0, so a frame never mixes two geometries. A test input makes the line counter advance on every cycle instead of once per line. Software can use this to skip lines and shorten a frame. The cycle counter keeps running while the test input is high.

The block has only control and status pins and no streaming data, so it has no valid/ready handshake.

Top module: `raster_timing`

## Requirements
- R1: While `rst_n` is low, the block loads the standard from `std_sel`. After the first clock edge with reset low, `line_cnt` and `cycle_cnt` are both 0 and the region flags describe line 0 of that standard.
- R2: `std_sel` is decoded as follows: 2'b00 selects 262 lines of 64 cycles, 2'b01 selects 263 lines of 65 cycles, and 2'b10 or 2'b11 selects 312 lines of 63 cycles. `cycle_cnt` counts 0 up to (cycles per line − 1) and then returns to 0.
- R3: When `test_en` is low, `line_cnt` increments on the cycle where `cycle_cnt` wraps. It goes from (lines per frame − 1) to 0. Bit 8 of `line_cnt` is set exactly for lines 256 and above.
- R4: In the 312-line standard: `top_border` covers lines 16–50, `display` covers 51–250 and `bottom_border` covers 251–299. `vblank` covers 300 through the end of the frame and lines 0–15.
- R5: In the 262- and 263-line standards: `top_border` covers lines 41–50, `display` covers 51–250, `vblank` covers 13–40, and `bottom_border` covers 251 through the end of the frame plus lines 0–12.
- R6: `badline_win` is high exactly for lines 48 to 247 in every standard.
- R7: While `test_en` is high, `line_cnt` advances by one on every cycle, and `cycle_cnt` is unaffected. Holding `test_en` high for 25 cycles starting at line 20 leaves the counter at line 45. Stepping past the last line wraps to 0.
- R8: A change on `std_sel` has no effect until the cycle in which `line_cnt` wraps to 0. From that cycle on, the new standard sets both the line geometry and the region decode.
- R9: The region flags are registered. In every cycle they describe the `line_cnt` value presented in that same cycle, and exactly one of the four region flags is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one video cycle per edge |
| rst_n | input | 1 | Synchronous active-low reset |
| std_sel | input | 2 | Frame standard select (see R2) |
| test_en | input | 1 | Line counter advances every cycle while high |
| line_cnt | output | 9 | Current raster line |
| cycle_cnt | output | 7 | Current cycle within the line |
| top_border | output | 1 | Line is in the top border |
| display | output | 1 | Line is in the display area |
| bottom_border | output | 1 | Line is in the bottom border |
| vblank | output | 1 | Line is in vertical blank |
| badline_win | output | 1 | Line lies in the bad-line window |

## Verification
The assertions assume that `std_sel` and `test_en` can take any value on any cycle. They also assume the active standard comes only from values the decoder accepts, so any 2-bit input is legal and there are no input rules to keep. The properties check how the counters step (hold, step by one, or wrap to 0), that the region flags are one-hot, and that the bad-line flag stays inside its line range. The stimulus changes `std_sel` in the middle of a frame to exercise the frame-boundary load. It raises `test_en` for runs that straddle a line wrap and for runs that cross the last line of the frame. Across these runs it visits all three standards and the alias encoding.

// File: rtl/rt_pkg.sv
package rt_pkg;

  typedef enum logic [1:0] {
    STD_SHORT64 = 2'b00,
    STD_SHORT65 = 2'b01,
    STD_LONG63  = 2'b10,
    STD_LONG63B = 2'b11
  } std_e;

  typedef struct packed {
    logic top;
    logic disp;
    logic bot;
    logic vblank;
    logic badline;
  } region_t;

  function automatic logic is_short(input std_e s);
    return (s == STD_SHORT64) || (s == STD_SHORT65);
  endfunction

endpackage

// File: rtl/rt_std_table.sv
module rt_std_table
  import rt_pkg::*;
#(
  parameter int LINE_W   = 9,
  parameter int CYC_W    = 7,
  parameter int S64_LINES = 262,
  parameter int S64_CYCS  = 64,
  parameter int S65_LINES = 263,
  parameter int S65_CYCS  = 65,
  parameter int L63_LINES = 312,
  parameter int L63_CYCS  = 63
) (
  input  std_e              std,
  output logic [LINE_W-1:0] last_line,
  output logic [CYC_W-1:0]  last_cyc
);
  localparam logic [LINE_W-1:0] S64_LL = LINE_W'(S64_LINES - 1);
  localparam logic [LINE_W-1:0] S65_LL = LINE_W'(S65_LINES - 1);
  localparam logic [LINE_W-1:0] L63_LL = LINE_W'(L63_LINES - 1);
  localparam logic [CYC_W-1:0]  S64_LC = CYC_W'(S64_CYCS - 1);
  localparam logic [CYC_W-1:0]  S65_LC = CYC_W'(S65_CYCS - 1);
  localparam logic [CYC_W-1:0]  L63_LC = CYC_W'(L63_CYCS - 1);

  always_comb begin
    unique case (std)
      STD_SHORT64: begin last_line = S64_LL; last_cyc = S64_LC; end
      STD_SHORT65: begin last_line = S65_LL; last_cyc = S65_LC; end
      default:     begin last_line = L63_LL; last_cyc = L63_LC; end
    endcase
  end
endmodule

// File: rtl/rt_counters.sv
module rt_counters #(
  parameter int LINE_W = 9,
  parameter int CYC_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_en,
  input  logic [LINE_W-1:0] last_line,
  input  logic [CYC_W-1:0]  last_cyc,
  output logic [LINE_W-1:0] line_q,
  output logic [CYC_W-1:0]  cyc_q,
  output logic [LINE_W-1:0] line_nxt,
  output logic              frame_wrap
);
  logic             cyc_wrap;
  logic             line_step;
  logic [CYC_W-1:0] cyc_nxt;

  // ">=" lets a counter left beyond a shorter new geometry still wrap
  assign cyc_wrap   = (cyc_q >= last_cyc);
  assign line_step  = test_en || cyc_wrap;
  assign frame_wrap = rst_n && line_step && (line_q >= last_line);

  always_comb begin
    if (!rst_n) begin
      cyc_nxt  = '0;
      line_nxt = '0;
    end else begin
      cyc_nxt  = cyc_wrap ? '0 : cyc_q + 1'b1;
      if (!line_step)      line_nxt = line_q;
      else if (frame_wrap) line_nxt = '0;
      else                 line_nxt = line_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    cyc_q  <= cyc_nxt;
    line_q <= line_nxt;
  end
endmodule

// File: rtl/rt_region_decode.sv
module rt_region_decode
  import rt_pkg::*;
#(
  parameter int LINE_W        = 9,
  parameter int LONG_TOP      = 16,
  parameter int SHORT_TOP     = 41,
  parameter int DISP_FIRST    = 51,
  parameter int DISP_LAST     = 250,
  parameter int LONG_VB_FIRST = 300,
  parameter int SHORT_VB_FIRST = 13,
  parameter int BAD_FIRST     = 48,
  parameter int BAD_LAST      = 247
) (
  input  logic [LINE_W-1:0] line,
  input  logic              short_frame,
  output region_t           r
);
  localparam logic [LINE_W-1:0] L_TOP  = LINE_W'(LONG_TOP);
  localparam logic [LINE_W-1:0] S_TOP  = LINE_W'(SHORT_TOP);
  localparam logic [LINE_W-1:0] D_LO   = LINE_W'(DISP_FIRST);
  localparam logic [LINE_W-1:0] D_HI   = LINE_W'(DISP_LAST);
  localparam logic [LINE_W-1:0] L_VB   = LINE_W'(LONG_VB_FIRST);
  localparam logic [LINE_W-1:0] S_VB   = LINE_W'(SHORT_VB_FIRST);
  localparam logic [LINE_W-1:0] B_LO   = LINE_W'(BAD_FIRST);
  localparam logic [LINE_W-1:0] B_HI   = LINE_W'(BAD_LAST);

  logic in_disp, below_disp;

  assign in_disp    = (line >= D_LO) && (line <= D_HI);
  assign below_disp = (line > D_HI);

  always_comb begin
    r         = '0;
    r.disp    = in_disp;
    r.badline = (line >= B_LO) && (line <= B_HI);
    if (short_frame) begin
      r.top    = (line >= S_TOP) && (line < D_LO);
      r.vblank = (line >= S_VB) && (line < S_TOP);
      r.bot    = below_disp || (line < S_VB);
    end else begin
      r.top    = (line >= L_TOP) && (line < D_LO);
      r.bot    = below_disp && (line < L_VB);
      r.vblank = (line >= L_VB) || (line < L_TOP);
    end
  end
endmodule

// File: rtl/raster_timing.sv
module raster_timing
  import rt_pkg::*;
#(
  parameter int LINE_W = 9,
  parameter int CYC_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        std_sel,
  input  logic              test_en,
  output logic [LINE_W-1:0] line_cnt,
  output logic [CYC_W-1:0]  cycle_cnt,
  output logic              top_border,
  output logic              display,
  output logic              bottom_border,
  output logic              vblank,
  output logic              badline_win
);
  std_e              act_std, nxt_std;
  logic [LINE_W-1:0] last_line, line_nxt;
  logic [CYC_W-1:0]  last_cyc;
  logic              frame_wrap;
  region_t           reg_nxt, reg_q;

  rt_std_table #(.LINE_W(LINE_W), .CYC_W(CYC_W)) u_tab (
    .std(act_std), .last_line(last_line), .last_cyc(last_cyc)
  );

  rt_counters #(.LINE_W(LINE_W), .CYC_W(CYC_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .test_en(test_en),
    .last_line(last_line), .last_cyc(last_cyc),
    .line_q(line_cnt), .cyc_q(cycle_cnt),
    .line_nxt(line_nxt), .frame_wrap(frame_wrap)
  );

  // standard is sampled only at reset or at the frame wrap
  assign nxt_std = (!rst_n || frame_wrap) ? std_e'(std_sel) : act_std;

  rt_region_decode #(.LINE_W(LINE_W)) u_dec (
    .line(line_nxt), .short_frame(is_short(nxt_std)), .r(reg_nxt)
  );

  always_ff @(posedge clk) begin
    act_std <= nxt_std;
    reg_q   <= reg_nxt;
  end

  assign top_border    = reg_q.top;
  assign display       = reg_q.disp;
  assign bottom_border = reg_q.bot;
  assign vblank        = reg_q.vblank;
  assign badline_win   = reg_q.badline;
endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
  parameter int LINE_W = 9,
  parameter int CYC_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              test_en,
  input logic [LINE_W-1:0] line_cnt,
  input logic [CYC_W-1:0]  cycle_cnt,
  input logic              top_border,
  input logic              display,
  input logic              bottom_border,
  input logic              vblank,
  input logic              badline_win
);
  p_cycle_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (cycle_cnt == $past(cycle_cnt) + 1'b1) || (cycle_cnt == '0));

  p_line_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !test_en) |=> (cycle_cnt == '0) || $stable(line_cnt));

  p_test_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && test_en) |=> (line_cnt == $past(line_cnt) + 1'b1) || (line_cnt == '0));

  p_regions_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({top_border, display, bottom_border, vblank}) == 1);

  p_badline_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    badline_win |-> (line_cnt >= 48) && (line_cnt <= 247) && (display || top_border));

  p_display_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    display |-> (line_cnt >= 51) && (line_cnt <= 250));
endmodule

bind raster_timing rt_checker #(.LINE_W(LINE_W), .CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_en(test_en), .line_cnt(line_cnt),
  .cycle_cnt(cycle_cnt), .top_border(top_border), .display(display),
  .bottom_border(bottom_border), .vblank(vblank), .badline_win(badline_win)
);

// File: tb/tb_raster_timing.sv
module tb_raster_timing;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] std_sel = 2'b10;
  logic       test_en = 1'b0;
  logic [8:0] line_cnt;
  logic [6:0] cycle_cnt;
  logic       top_border, display, bottom_border, vblank, badline_win;

  int checks = 0, failures = 0;
  int m_line = 0, m_cyc = 0, m_std = 2;
  bit done = 0;

  raster_timing dut (
    .clk(clk), .rst_n(rst_n), .std_sel(std_sel), .test_en(test_en),
    .line_cnt(line_cnt), .cycle_cnt(cycle_cnt), .top_border(top_border),
    .display(display), .bottom_border(bottom_border), .vblank(vblank),
    .badline_win(badline_win)
  );

  always #4 clk = ~clk;

  function automatic int lines_of(int s);
    return (s == 0) ? 262 : (s == 1) ? 263 : 312;
  endfunction
  function automatic int cycs_of(int s);
    return (s == 0) ? 64 : (s == 1) ? 65 : 63;
  endfunction
  // expected flags {top, disp, bot, vblank, badline} from requirements R4/R5/R6
  function automatic logic [4:0] exp_flags(int ln, int s);
    logic t, d, b, v, bl;
    d  = (ln >= 51 && ln <= 250);
    bl = (ln >= 48 && ln <= 247);
    if (s < 2) begin
      t = (ln >= 41 && ln <= 50); v = (ln >= 13 && ln <= 40);
      b = (ln >= 251 || ln <= 12);
    end else begin
      t = (ln >= 16 && ln <= 50); b = (ln >= 251 && ln <= 299);
      v = (ln >= 300 || ln <= 15);
    end
    return {t, d, b, v, bl};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      if (failures < 20) $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model, advanced at every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_line = 0; m_cyc = 0; m_std = std_sel;
    end else begin
      bit cw, step;
      cw = (m_cyc >= cycs_of(m_std) - 1);
      step = test_en || cw;
      m_cyc = cw ? 0 : m_cyc + 1;
      if (step) begin
        if (m_line >= lines_of(m_std) - 1) begin
          m_line = 0; m_std = std_sel;
        end else m_line = m_line + 1;
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 cycle", cycle_cnt, m_cyc);
      chk("R3 line", line_cnt, m_line);
      chk("R9 flags", {top_border, display, bottom_border, vblank, badline_win},
          exp_flags(m_line, m_std));
    end
  end

  task automatic wait_line(input int ln);
    do @(negedge clk); while (line_cnt != 9'(ln));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset line", line_cnt, 0);
    chk("R1 reset cycle", cycle_cnt, 0);
    chk("R1 reset flags", {top_border, display, bottom_border, vblank, badline_win},
        exp_flags(0, 2));
    rst_n = 1'b1;

    // R4: long standard, full frame; R3 msb check at line 300
    wait_line(300);
    chk("R3 msb set", line_cnt[8], 1);
    chk("R4 vblank at 300", vblank, 1);
    std_sel = 2'b00;                      // R8: change mid-frame
    @(negedge clk);
    chk("R8 no early effect", vblank, 1);
    wait_line(0);
    chk("R3 msb clear at wrap", line_cnt[8], 0);
    chk("R5 bottom at 0 short", bottom_border, 1);

    // R7: steal 25 lines starting at line 20
    wait_line(20);
    test_en = 1'b1;
    repeat (25) @(negedge clk);
    test_en = 1'b0;
    chk("R7 line after steal", line_cnt, 45);
    chk("R5 top at 45", top_border, 1);

    // R7: test mode through end of frame
    wait_line(255);
    test_en = 1'b1;
    std_sel = 2'b01;
    repeat (10) @(negedge clk);
    test_en = 1'b0;
    chk("R7 wrap through end", line_cnt, 3);

    // R2/R5: 263x65 frame, then alias encoding
    wait_line(262);
    chk("R2 263 lines", line_cnt, 262);
    std_sel = 2'b11;
    wait_line(0);
    wait_line(48);
    chk("R6 badline at 48", badline_win, 1);
    chk("R4 top at 48 long", top_border, 1);
    wait_line(311);
    chk("R2 alias 312 lines", line_cnt, 311);
    wait_line(1);
    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 150000) begin @(posedge clk); n++; end
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=done", n);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule